// File: doc/BRIEF.md
# Free-Running Timer with Compare and Capture

This block is a free-running up-counter with a selectable clock divider. A set of channels watches the count. Five compare channels detect when the count reaches a programmed value. Each one raises a flag and may act on a pin. The first compare is a master: a single match can force several pins at once, using a pin mask and a data pattern. The other four compares each own one pin and can set, clear or toggle it.

Three capture channels sample the count on a chosen edge of a synchronised input. A fourth capture shares its register, flag and pin slot with the fifth compare, and a control bit picks which of the two the channel acts as. Every timer function has a flag, and the counter also has a wrap flag. Each flag has an enable bit, and one interrupt line reports any flag whose enable bit is set.

Software uses a simple register bus with one write strobe and registered read data. Reset places every part in a quiet state: the compare registers hold all ones, no pin actions are enabled, captures are disabled, and all flags and enables are cleared.

Top module: `tmr_top`

## Requirements
- R1: After reset the count is 0, the divider select is 0, all five compare registers read 0xFFFF, and the following all read 0: the action register (addr 10), the master register (addr 11), the edge register (addr 12), the flag register (addr 13), the enable register (addr 14) and the control register (addr 9). The pins and the interrupt are 0.
- R2: The count (addr 0) rises by one per divider tick. Control bits [1:0] select the divider: code 0 gives /1, code 1 gives /4, code 2 gives /8 and code 3 gives /16.
- R3: When the count passes from all ones to zero, flag bit 8 is set.
- R4: Compare k (k = 2..5, addr k) sets flag bit k-1 in the edge where the count becomes equal to its value. It also applies the 2-bit action held at addr 10 bits [2(k-2)+1:2(k-2)] to pin k-1. The action codes are 0 none, 1 toggle, 2 clear and 3 set.
- R5: When compare 1 (addr 1) matches, flag bit 0 is set. Each pin whose bit is set in addr 11 [4:0] takes the matching bit of addr 11 [12:8]. This master action wins over any other compare acting on the same pin in the same edge. With a zero mask, no pin changes.
- R6: Each capture input passes through a two-stage synchroniser. The edge register addr 12 holds 2 bits per channel (capture c at bits [2c-1:2c-2]), with codes 0 off, 1 rising, 2 falling and 3 any edge. On the selected edge, the count is latched into the capture register (captures 1..3 at addr 6..8) and flag bit 4+c is set.
- R7: Control bit 2 selects the shared channel. When it is 0, the channel is compare 5. When it is 1, input 3 captures into addr 5 and sets flag bit 4, and compare 5 neither matches nor moves pin 4.
- R8: Writing 1 to a bit of addr 13 clears that flag. Bits written as 0 are left unchanged.
- R9: The interrupt output is 1 one edge after any flag is set whose enable bit in addr 14 is also set. It returns to 0 one edge after no such pair remains.
- R10: Read data is registered: it shows the register at `bus_addr` one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_addr | input | ADDR_W (4) | register address |
| bus_wdata | input | CNT_W (16) | write data |
| bus_rdata | output | CNT_W (16) | registered read data |
| cap_in | input | 4 | capture inputs; bit 3 feeds the shared channel |
| cmp_pin | output | 5 | compare-driven pins |
| irq | output | 1 | interrupt request |

## Verification
The bench measures divider rates over a window that is a multiple of every ratio, so a rate that is off by one step shows up as a wrong count difference. Capture values are checked as differences between channels. A wrong synchroniser depth or a swapped edge code therefore gives the wrong gap, or leaves a stale value behind. The master compare is made to collide with a "set" on the same pin, so a design that gives the individual compare priority leaves that pin high. In capture mode the shared channel is given a live compare action, so a design that fails to suppress compare 5 there moves pin 4.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_CMP  = 5;
  localparam int N_CAP  = 4;
  localparam int N_FLAG = 9;
  localparam int FLG_CAP0 = 5;
  localparam int FLG_OVF  = 8;

  localparam int A_CNT  = 0;
  localparam int A_CMP0 = 1;
  localparam int A_CAP0 = 6;
  localparam int A_CTL  = 9;
  localparam int A_ACT  = 10;
  localparam int A_MST  = 11;
  localparam int A_EDGE = 12;
  localparam int A_FLG  = 13;
  localparam int A_ENA  = 14;

  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_TOGGLE, ACT_CLEAR, ACT_SET} act_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       psel,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             wrap
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] pre_mask;

  always_comb begin
    case (psel)
      2'd0:    pre_mask = '0;
      2'd1:    pre_mask = PRE_W'(3);
      2'd2:    pre_mask = PRE_W'(7);
      default: pre_mask = PRE_W'(15);
    endcase
  end

  assign tick = (pre & pre_mask) == pre_mask;
  assign wrap = tick && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  // R2: at divide-by-16 two ticks are never adjacent
  assert_div16_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && psel == 2'd3) |=> (psel != 2'd3 || !tick));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   pin_in,
  input  logic [2*N-1:0] cfg,
  output logic [N-1:0]   evt
);
  import tmr_pkg::*;
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic rise, fall;
    assign rise = s2[c] & ~s3[c];
    assign fall = ~s2[c] & s3[c];
    always_comb begin
      case (edge_e'(cfg[2*c +: 2]))
        EDGE_RISE: evt[c] = rise;
        EDGE_FALL: evt[c] = fall;
        EDGE_ANY:  evt[c] = rise | fall;
        default:   evt[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_pins.sv
module tmr_pins #(
  parameter int N = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     hit,
  input  logic [2*N-3:0]   act,
  input  logic [N-1:0]     mmask,
  input  logic [N-1:0]     mdata,
  output logic [N-1:0]     pins
);
  import tmr_pkg::*;
  logic [N-1:0] nxt;

  for (genvar p = 0; p < N; p++) begin : g_pin
    logic own;
    if (p == 0) begin : g_master_only
      assign own = pins[0];
    end else begin : g_owned
      always_comb begin
        own = pins[p];
        if (hit[p]) begin
          case (act_e'(act[2*(p-1) +: 2]))
            ACT_TOGGLE: own = ~pins[p];
            ACT_CLEAR:  own = 1'b0;
            ACT_SET:    own = 1'b1;
            default:    own = pins[p];
          endcase
        end
      end
    end
    assign nxt[p] = (hit[0] && mmask[p]) ? mdata[p] : own;

    // R5: a master match forces the masked pin to the data bit
    assert_master_wins_R5: assert property (@(posedge clk) disable iff (rst)
      (hit[0] && mmask[p]) |=> (pins[p] == $past(mdata[p])));
  end

  always_ff @(posedge clk) begin
    if (rst) pins <= '0;
    else     pins <= nxt;
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [3:0]        cap_in,
  output logic [4:0]        cmp_pin,
  output logic              irq
);
  import tmr_pkg::*;
  localparam int N_ACT = 2 * (N_CMP - 1);

  logic [CNT_W-1:0]  cnt, cnt_inc;
  logic              tick, wrap;
  logic [1:0]        psel;
  logic              share;
  logic [CNT_W-1:0]  cmp [N_CMP];
  logic [CNT_W-1:0]  capr [N_CAP-1];
  logic [N_ACT-1:0]  act;
  logic [N_CMP-1:0]  mmask, mdata;
  logic [2*N_CAP-1:0] ecfg;
  logic [N_FLAG-1:0] flags, enab, fset, fclr;
  logic [N_CMP-1:0]  match;
  logic [N_CAP-1:0]  evt, cap_hit;
  logic [CNT_W-1:0]  rd_nxt;
  int                a;

  assign a = int'(bus_addr);
  assign cnt_inc = cnt + 1'b1;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .psel(psel), .cnt(cnt), .tick(tick), .wrap(wrap));

  tmr_capture #(.N(N_CAP)) u_cap (
    .clk(clk), .rst(rst), .pin_in(cap_in), .cfg(ecfg), .evt(evt));

  tmr_pins #(.N(N_CMP)) u_pins (
    .clk(clk), .rst(rst), .hit(match), .act(act),
    .mmask(mmask), .mdata(mdata), .pins(cmp_pin));

  for (genvar k = 0; k < N_CMP; k++) begin : g_match
    if (k == N_CMP - 1) begin : g_shared
      assign match[k] = tick && !share && (cnt_inc == cmp[k]);
    end else begin : g_plain
      assign match[k] = tick && (cnt_inc == cmp[k]);
    end
  end

  assign cap_hit = {evt[N_CAP-1] & share, evt[N_CAP-2:0]};
  assign fset = {wrap, cap_hit[N_CAP-2:0], match[N_CMP-1] | cap_hit[N_CAP-1],
                 match[N_CMP-2:0]};
  assign fclr = (bus_wr && a == A_FLG) ? bus_wdata[N_FLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_CMP; k++) cmp[k] <= '1;
      for (int c = 0; c < N_CAP-1; c++) capr[c] <= '0;
      psel <= '0; share <= 1'b0; act <= '0;
      mmask <= '0; mdata <= '0; ecfg <= '0;
      flags <= '0; enab <= '0; irq <= 1'b0;
    end else begin
      if (bus_wr) begin
        for (int k = 0; k < N_CMP; k++)
          if (a == A_CMP0 + k) cmp[k] <= bus_wdata;
        if (a == A_CTL) begin
          psel  <= bus_wdata[1:0];
          share <= bus_wdata[2];
        end
        if (a == A_ACT)  act  <= bus_wdata[N_ACT-1:0];
        if (a == A_MST) begin
          mmask <= bus_wdata[N_CMP-1:0];
          mdata <= bus_wdata[8 +: N_CMP];
        end
        if (a == A_EDGE) ecfg <= bus_wdata[2*N_CAP-1:0];
        if (a == A_ENA)  enab <= bus_wdata[N_FLAG-1:0];
      end
      for (int c = 0; c < N_CAP-1; c++)
        if (cap_hit[c]) capr[c] <= cnt;
      if (cap_hit[N_CAP-1]) cmp[N_CMP-1] <= cnt;
      flags <= (flags & ~fclr) | fset;
      irq   <= |(flags & enab);
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (a)
      A_CNT:  rd_nxt = cnt;
      A_CTL:  rd_nxt = CNT_W'({share, psel});
      A_ACT:  rd_nxt = CNT_W'(act);
      A_MST:  rd_nxt = CNT_W'({mdata, 3'b000, mmask});
      A_EDGE: rd_nxt = CNT_W'(ecfg);
      A_FLG:  rd_nxt = CNT_W'(flags);
      A_ENA:  rd_nxt = CNT_W'(enab);
      default: rd_nxt = '0;
    endcase
    for (int k = 0; k < N_CMP; k++)
      if (a == A_CMP0 + k) rd_nxt = cmp[k];
    for (int c = 0; c < N_CAP-1; c++)
      if (a == A_CAP0 + c) rd_nxt = capr[c];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

  // R3: a wrap of the count leaves the overflow flag set
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flags[FLG_OVF]);

  // R6: a capture on channel 1 leaves its flag set
  assert_cap_flag_R6: assert property (@(posedge clk) disable iff (rst)
    cap_hit[0] |=> flags[FLG_CAP0]);

  // R7: in capture mode only the master compare may move pin 4
  assert_shared_pin_R7: assert property (@(posedge clk) disable iff (rst)
    (share && !(match[0] && mmask[4])) |=> $stable(cmp_pin[4]));

  // R9: no enabled flag means no request on the following edge
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((flags & enab) == '0) |=> !irq);
endmodule

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic [4:0]  cmp_pin;
  logic        irq;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  tmr_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_pin(cmp_pin), .irq(irq));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int adr, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(adr); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int adr, output int v);
    @(negedge clk);
    bus_addr = 4'(adr);
    @(posedge clk);
    #1 v = int'(bus_rdata);
  endtask

  task automatic t_reset;
    int v;
    rd(0, v); chk("R1", "count near zero", int'(v <= 3), 1);
    for (int k = 1; k <= 5; k++) begin
      rd(k, v); chk("R1", "compare reset", v, 16'hFFFF);
    end
    for (int r = 9; r <= 14; r++) begin
      rd(r, v); chk("R1", "control reset", v, 0);
    end
    chk("R1", "pins reset", int'(cmp_pin), 0);
    chk("R1", "irq reset", int'(irq), 0);
  endtask

  task automatic t_prescale;
    int v0, v1;
    int exp_d [4] = '{160, 40, 20, 10};
    for (int p = 0; p < 4; p++) begin
      wr(9, p);
      rd(0, v0); cyc(159); rd(0, v1);
      chk("R2", "count rate", (v1 - v0) & 16'hFFFF, exp_d[p]);
    end
    wr(9, 0);
  endtask

  task automatic t_compare;
    int c, t, f;
    wr(13, 16'h1FF);
    rd(0, c); t = (c + 80) & 16'hFFFF;
    wr(2, t); wr(3, t); wr(4, t); wr(5, t);
    wr(10, 16'h27);
    cyc(20);
    chk("R4", "no early pin", int'(cmp_pin), 0);
    rd(13, f); chk("R4", "no early flag", f & 16'h1E, 0);
    cyc(80);
    chk("R4", "set/toggle/clear/none", int'(cmp_pin), 5'b00110);
    rd(13, f); chk("R4", "flags 1..4", f & 16'h1E, 16'h1E);
    wr(13, 16'h1FF);
    rd(0, c); t = (c + 40) & 16'hFFFF;
    wr(10, 16'h26); wr(2, t); wr(3, t);
    cyc(60);
    chk("R4", "clear and re-toggle", int'(cmp_pin), 0);
  endtask

  task automatic t_master;
    int c, t, f;
    wr(13, 16'h1FF);
    wr(10, 16'h03);
    wr(11, 16'h0507);
    rd(0, c); t = (c + 40) & 16'hFFFF;
    wr(1, t); wr(2, t);
    cyc(60);
    chk("R5", "master overrides set", int'(cmp_pin), 5'b00101);
    rd(13, f); chk("R5", "master flag", f & 1, 1);
    wr(13, 16'h1FF);
    wr(11, 16'h1F00);
    rd(0, c); t = (c + 40) & 16'hFFFF;
    wr(1, t);
    cyc(60);
    chk("R5", "zero mask keeps pins", int'(cmp_pin), 5'b00101);
    rd(13, f); chk("R5", "zero mask flag", f & 1, 1);
  endtask

  task automatic t_capture;
    int f, v1, v2, v3;
    wr(13, 16'h1FF);
    cyc(1); cap_in[0] = 1'b1; cyc(4); cap_in[0] = 1'b0; cyc(5);
    rd(13, f); chk("R6", "disabled capture", f & 16'hE0, 0);
    wr(12, 16'h39);
    cyc(1); cap_in[0] = 1'b1;
    cyc(5); cap_in[1] = 1'b1;
    cyc(3);
    rd(13, f); chk("R6", "falling ignores rise", (f >> 6) & 1, 0);
    cyc(1); cap_in[1] = 1'b0;
    cyc(2); cap_in[2] = 1'b1;
    cyc(8); cap_in[2] = 1'b0;
    cyc(10);
    rd(6, v1); rd(7, v2); rd(8, v3);
    chk("R6", "falling capture gap", (v2 - v1) & 16'hFFFF, 10);
    chk("R6", "any-edge last capture gap", (v3 - v1) & 16'hFFFF, 20);
    rd(13, f); chk("R6", "capture flags", f & 16'hE0, 16'hE0);
  endtask

  task automatic t_shared;
    int c, t, f, v5, v6;
    wr(9, 4);
    wr(13, 16'h1FF);
    wr(10, 16'hC0);
    rd(0, c); t = (c + 40) & 16'hFFFF;
    wr(5, t);
    cyc(60);
    chk("R7", "capture mode pin4 idle", int'(cmp_pin), 5'b00101);
    rd(13, f); chk("R7", "no compare5 flag", (f >> 4) & 1, 0);
    wr(12, 16'h79);
    cap_in[0] = 1'b0; cyc(5);
    cap_in[0] = 1'b1; cyc(7);
    cap_in[3] = 1'b1; cyc(10);
    rd(5, v5); rd(6, v6);
    chk("R7", "shared capture gap", (v5 - v6) & 16'hFFFF, 7);
    rd(13, f); chk("R7", "shared capture flag", (f >> 4) & 1, 1);
    wr(9, 0);
    rd(0, c); t = (c + 40) & 16'hFFFF;
    wr(5, t);
    cyc(60);
    chk("R7", "compare mode sets pin4", int'(cmp_pin), 5'b10101);
  endtask

  task automatic t_flags;
    int f;
    wr(14, 16'h020);
    cyc(2);
    chk("R9", "irq on enabled flag", int'(irq), 1);
    wr(13, 0);
    rd(13, f); chk("R8", "zero write keeps", (f >> 4) & 3, 3);
    wr(13, 16'h010);
    rd(13, f); chk("R8", "clear one bit only", (f >> 4) & 3, 2);
    chk("R9", "irq held", int'(irq), 1);
    wr(13, 16'h020);
    cyc(2);
    chk("R9", "irq drops", int'(irq), 0);
    rd(13, f); chk("R8", "bit cleared", (f >> 5) & 1, 0);
  endtask

  task automatic t_overflow;
    int c, d, f;
    wr(13, 16'h1FF);
    wr(14, 16'h100);
    rd(0, c); d = 65536 - c;
    if (d < 200) begin
      cyc(d + 50); wr(13, 16'h1FF); rd(0, c); d = 65536 - c;
    end
    cyc(d - 60);
    rd(13, f); chk("R3", "no early wrap flag", (f >> 8) & 1, 0);
    chk("R9", "no early irq", int'(irq), 0);
    cyc(100);
    rd(13, f); chk("R3", "wrap flag", (f >> 8) & 1, 1);
    chk("R9", "irq on wrap", int'(irq), 1);
  endtask

  task automatic t_readlat;
    int v;
    wr(1, 16'h1234);
    rd(1, v); chk("R10", "read after one edge", v, 16'h1234);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    t_reset;
    t_prescale;
    t_compare;
    t_master;
    t_capture;
    t_shared;
    t_flags;
    t_readlat;
    t_overflow;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule